// File: doc/BRIEF.md
# Composite memory select generator

This block drives the chip-select outputs of an external memory bus. Four raw select requests arrive from the address decoder, one for each memory space: program, data, boot and I/O. The block passes each of them to its own active-low pin. It also drives one more active-low pin, the composite select, which asserts whenever any request whose enable bit is set asserts. With the composite select, one physical memory can answer in more than one space. For example, with the program and data bits enabled, one memory serves both spaces and one of the individual selects acts as an extra address bit.

All five outputs come out of one rank of flops, so the composite select has exactly the timing of the individual selects. While the bus is granted to an external master, every output is held high.

A system-control bit turns off the boot select pin on its own. Booting can then use one external memory while DMA transfers go to another memory through the composite select. A small write port loads the enable mask and the system-control bit.

Top module: `memsel_combine`

## Requirements
- R1: After reset, all five outputs are high. The enable mask resets to 1 for program (bit 0), data (bit 1) and I/O (bit 3), and to 0 for boot (bit 2). The boot-disable bit resets to 0.
- R2: When `bus_grant_i` is low at a rising edge, `sel_n_o[i]` after that edge equals the inverse of `req_i[i]` sampled at that edge, for i = 0, 1, 3, and for i = 2 while boot-disable is 0.
- R3: `cms_n_o` after a rising edge is low exactly when some `req_i[i]` with enable bit i set was high at that edge and `bus_grant_i` was low. It changes on the same edge as the individual selects.
- R4: While the boot-disable bit is 1, `sel_n_o[2]` stays high whatever `req_i[2]` is. The other individual selects are unaffected.
- R5: Boot-disable has no effect on the composite select. A boot request still drives `cms_n_o` low when enable bit 2 is set.
- R6: While `bus_grant_i` is high at an edge, all five outputs are high after that edge.
- R7: A write with `cfg_addr_i`=0 loads the enable mask from `cfg_wdata_i[3:0]`. A write with `cfg_addr_i`=1 loads boot-disable from `cfg_wdata_i[3]`. All other data bits are ignored. A write at edge k affects outputs only from edge k+1 on; the outputs at edge k still use the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Raw select requests, active high: bit 0 program, 1 data, 2 boot, 3 I/O |
| bus_grant_i | input | 1 | High while an external master owns the bus |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1 | 0 selects the enable mask, 1 selects system control |
| cfg_wdata_i | input | 16 | Configuration write data |
| sel_n_o | output | 4 | Gated individual selects, active low |
| cms_n_o | output | 1 | Composite select, active low |

## Verification
The hardest case to reach is the one where a boot request is suppressed at its own pin but still drives the composite select. It needs three things at once: boot-disable written to 1, enable bit 2 written to 1 (it resets to 0), and a boot request with no bus grant. Directed writes set up both registers before the boot request. Random writes with random data also land on every mix of mask and disable bit. A directed write placed on the same edge as an active request checks that the old mask still decides that edge.

// File: rtl/memsel_pkg.sv
package memsel_pkg;
   localparam int SPACE_PROG = 0;
   localparam int SPACE_DATA = 1;
   localparam int SPACE_BOOT = 2;
   localparam int SPACE_IO   = 3;

   typedef enum logic {
      CFG_ENABLE = 1'b0,
      CFG_SYSCTL = 1'b1
   } cfg_addr_e;
endpackage

// File: rtl/memsel_cfg_regs.sv
module memsel_cfg_regs #(
   parameter int NUM_SEL     = 4,
   parameter int DATA_W      = 16,
   parameter int BOOTDIS_BIT = 3,
   parameter logic [NUM_SEL-1:0] EN_RST = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we_i,
   input  logic               cfg_addr_i,
   input  logic [DATA_W-1:0]  cfg_wdata_i,
   output logic [NUM_SEL-1:0] en_o,
   output logic               boot_dis_o
);
   import memsel_pkg::*;

   logic unused_wdata;
   assign unused_wdata = ^cfg_wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o       <= EN_RST;
         boot_dis_o <= 1'b0;
      end else if (cfg_we_i) begin
         if (cfg_addr_i == CFG_ENABLE)
            en_o <= cfg_wdata_i[NUM_SEL-1:0];
         else
            boot_dis_o <= cfg_wdata_i[BOOTDIS_BIT];
      end
   end
endmodule

// File: rtl/memsel_gate.sv
module memsel_gate #(
   parameter int NUM_SEL  = 4,
   parameter int BOOT_IDX = 2
) (
   input  logic [NUM_SEL-1:0] req_i,
   input  logic               grant_i,
   input  logic [NUM_SEL-1:0] en_i,
   input  logic               boot_dis_i,
   output logic [NUM_SEL-1:0] pin_act_o,
   output logic               cms_act_o
);
   logic [NUM_SEL-1:0] owned;
   logic [NUM_SEL-1:0] cms_term;

   for (genvar i = 0; i < NUM_SEL; i++) begin : g_space
      assign owned[i] = req_i[i] & ~grant_i;
      if (i == BOOT_IDX) begin : g_boot
         assign pin_act_o[i] = owned[i] & ~boot_dis_i;
      end else begin : g_plain
         assign pin_act_o[i] = owned[i];
      end
      assign cms_term[i] = owned[i] & en_i[i];
   end

   assign cms_act_o = |cms_term;
endmodule

// File: rtl/memsel_out_reg.sv
module memsel_out_reg #(
   parameter int NUM_SEL = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SEL-1:0] pin_act_i,
   input  logic               cms_act_i,
   output logic [NUM_SEL-1:0] sel_n_o,
   output logic               cms_n_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_n_o <= '1;
         cms_n_o <= 1'b1;
      end else begin
         sel_n_o <= ~pin_act_i;
         cms_n_o <= ~cms_act_i;
      end
   end
endmodule

// File: rtl/memsel_combine.sv
module memsel_combine #(
   parameter int NUM_SEL     = 4,
   parameter int BOOT_IDX    = memsel_pkg::SPACE_BOOT,
   parameter int DATA_W      = 16,
   parameter int BOOTDIS_BIT = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SEL-1:0] req_i,
   input  logic               bus_grant_i,
   input  logic               cfg_we_i,
   input  logic               cfg_addr_i,
   input  logic [DATA_W-1:0]  cfg_wdata_i,
   output logic [NUM_SEL-1:0] sel_n_o,
   output logic               cms_n_o
);
   localparam logic [NUM_SEL-1:0] EN_RST = ~(NUM_SEL'(1) << BOOT_IDX);

   if (BOOT_IDX >= NUM_SEL) begin : g_bad_boot
      $error("BOOT_IDX must index one of the selects");
   end
   if (BOOTDIS_BIT >= DATA_W || NUM_SEL > DATA_W) begin : g_bad_width
      $error("configuration fields must fit the write data");
   end

   logic [NUM_SEL-1:0] en;
   logic               boot_dis;
   logic [NUM_SEL-1:0] pin_act;
   logic               cms_act;

   memsel_cfg_regs #(
      .NUM_SEL(NUM_SEL), .DATA_W(DATA_W),
      .BOOTDIS_BIT(BOOTDIS_BIT), .EN_RST(EN_RST)
   ) cfg_i (
      .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i),
      .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
      .en_o(en), .boot_dis_o(boot_dis)
   );

   memsel_gate #(.NUM_SEL(NUM_SEL), .BOOT_IDX(BOOT_IDX)) gate_i (
      .req_i(req_i), .grant_i(bus_grant_i), .en_i(en),
      .boot_dis_i(boot_dis), .pin_act_o(pin_act), .cms_act_o(cms_act)
   );

   memsel_out_reg #(.NUM_SEL(NUM_SEL)) out_i (
      .clk(clk), .rst_n(rst_n), .pin_act_i(pin_act),
      .cms_act_i(cms_act), .sel_n_o(sel_n_o), .cms_n_o(cms_n_o)
   );
endmodule

// File: rtl/memsel_combine_chk.sv
module memsel_combine_chk #(
   parameter int NUM_SEL  = 4,
   parameter int BOOT_IDX = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SEL-1:0] req_i,
   input logic               bus_grant_i,
   input logic               cfg_we_i,
   input logic               cfg_addr_i,
   input logic               bootdis_bit,
   input logic [NUM_SEL-1:0] sel_n_o,
   input logic               cms_n_o
);
   logic shadow_bd;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       shadow_bd <= 1'b0;
      else if (cfg_we_i && cfg_addr_i)  shadow_bd <= bootdis_bit;
   end

   AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_grant_i |=> (sel_n_o == '1 && cms_n_o)); // R6
   AST_SEL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ((~sel_n_o) & ~$past(req_i)) == '0); // R2
   AST_PROG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_grant_i && req_i[0]) |=> !sel_n_o[0]); // R2
   AST_CMS_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !cms_n_o |-> ($past(req_i) != '0)); // R3
   AST_BOOT_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
      shadow_bd |=> sel_n_o[BOOT_IDX]); // R4
endmodule

bind memsel_combine memsel_combine_chk #(.NUM_SEL(NUM_SEL), .BOOT_IDX(BOOT_IDX)) chk_i (
   .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_grant_i(bus_grant_i),
   .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
   .bootdis_bit(cfg_wdata_i[BOOTDIS_BIT]),
   .sel_n_o(sel_n_o), .cms_n_o(cms_n_o)
);

// File: tb/memsel_combine_tb_top.sv
module memsel_combine_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic [3:0]  req_i = '0;
   logic        bus_grant_i = 1'b0;
   logic        cfg_we_i = 1'b0;
   logic        cfg_addr_i = 1'b0;
   logic [15:0] cfg_wdata_i = '0;
   logic [3:0]  sel_n_o;
   logic        cms_n_o;

   int checks = 0;
   int fails  = 0;
   logic [3:0] m_en = 4'b1011;
   logic       m_bd = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   memsel_combine dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_grant_i(bus_grant_i),
      .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
      .sel_n_o(sel_n_o), .cms_n_o(cms_n_o)
   );

   function automatic logic [4:0] expect_out(logic [3:0] rq, logic g,
                                             logic [3:0] en, logic bd);
      logic [3:0] pin;
      logic       cms;
      if (g) return 5'b11111;
      pin = rq & ~{1'b0, bd, 2'b00};
      cms = |(rq & en);
      return {~cms, ~pin};
   endfunction

   task automatic check(string tag, logic [4:0] exp);
      checks++;
      if ({cms_n_o, sel_n_o} !== exp) begin
         fails++;
         $display("FAIL %s: got cms_n=%b sel_n=%b, expected cms_n=%b sel_n=%b",
                  tag, cms_n_o, sel_n_o, exp[4], exp[3:0]);
      end
   endtask

   task automatic step(string tag, logic [3:0] rq, logic g,
                       logic we, logic addr, logic [15:0] wd);
      logic [4:0] exp;
      @(negedge clk);
      req_i = rq; bus_grant_i = g;
      cfg_we_i = we; cfg_addr_i = addr; cfg_wdata_i = wd;
      exp = expect_out(rq, g, m_en, m_bd);
      @(posedge clk);
      #1;
      check(tag, exp);
      if (we) begin
         if (!addr) m_en = wd[3:0];
         else       m_bd = wd[3];
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++; checks++;
      $display("FAIL watchdog: expired, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed));
      #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 check("R1 reset", 5'b11111);
      @(negedge clk) rst_n = 1'b1;
      // R1: reset mask, boot not in composite
      step("R1", 4'b0100, 0, 0, 0, 16'h0);
      step("R1", 4'b0001, 0, 0, 0, 16'h0);
      step("R2/R3", 4'b1111, 0, 0, 0, 16'h0);
      step("R3", 4'b1000, 0, 0, 0, 16'h0);
      // R6: grant blocks everything
      step("R6", 4'b1111, 1, 0, 0, 16'h0);
      // R7: write mask with garbage in upper bits; same edge uses old mask
      step("R7 same-edge", 4'b0001, 0, 1, 0, 16'hFFF4);
      step("R7", 4'b0001, 0, 0, 0, 16'h0);
      step("R7", 4'b0100, 0, 0, 0, 16'h0);
      // R4/R5: boot pin off, composite still follows boot
      step("R4", 4'b0000, 0, 1, 1, 16'h0008);
      step("R4/R5", 4'b0100, 0, 0, 0, 16'h0);
      step("R4", 4'b1111, 0, 0, 0, 16'h0);
      // R5: boot disabled and boot not enabled
      step("R5", 4'b0000, 0, 1, 0, 16'h0003);
      step("R5", 4'b0100, 0, 0, 0, 16'h0);
      // R7: sysctl write with bit 3 clear, other bits set
      step("R7", 4'b0000, 0, 1, 1, 16'hFFF7);
      step("R7/R2", 4'b0100, 0, 0, 0, 16'h0);
      step("R6", 4'b0100, 1, 0, 0, 16'h0);
      for (int n = 0; n < 3000; n++) begin
         logic [3:0]  rq = 4'($urandom);
         logic        g  = ($urandom % 8) == 0;
         logic        we = ($urandom % 6) == 0;
         logic        ad = 1'($urandom);
         logic [15:0] wd = 16'($urandom);
         step(g ? "R6" : "R2/R3/R4/R5/R7", rq, g, we, ad, wd);
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule